// File: doc/BRIEF.md
# Looping Test Vector Sequencer

This block plays a stored list of test vectors onto a bank of output channels. Each vector has two words. The level word gives the value of each channel. The enable word says, per channel, whether that value is driven or the pin is left at high impedance. The vectors come from two small synchronous memories inside the block, which are filled through the block's register write port. A run starts at a programmed first address and ends after a programmed last address has been driven. Inside that run, one address window can be replayed a programmed number of extra times before the sequence moves on past it.

One vector is driven for each drive pulse. The drive pulse comes from a source picked in the configuration register: an internal divider with four rates, an external clock on a selectable edge, a software strobe, or a strobe from a probe pod. A target handshake input can stall the sequence. An asynchronous active-low override floats every output at once. A vector whose drive pulse arrives while the override is still held low is used up but never reaches the pins. A capture pulse follows each driven vector after a programmable number of cycles. A small status word reports three states: running, stalled and finished.

Top module: `vseq_top`

## Requirements
- R1: After reset, every bit of vo_oe is 0, stat is 0 and cap_pulse is 0.
- R2: Writing register 7 sets the load pointer. Writing register 8 stores wr_data as the level word at the pointer. Writing register 9 stores wr_data as the enable word at the pointer and then increments the pointer.
- R3: While running, each drive pulse sets vo_lvl to the level word and vo_oe to the enable word of the current address. A 1 in the enable word drives the channel; a 0 leaves it at high impedance.
- R4: A write of 1 to bit 0 of register 6 starts a run at the address in register 1. The run moves forward one address per drive pulse. After the vector at the address in register 2 has been driven, stat[0] (running) clears and stat[2] (complete) sets.
- R5: When the vector at the address in register 4 is driven and the repeat count left is not zero, the next address is the one in register 3 and the count left drops by one. Otherwise the sequence falls through. The count left is loaded from register 5 at start, so the window runs that value plus one times.
- R6: While wait_in is high, drive pulses neither change the outputs nor advance the address, and stat[1] (waiting) is 1. The first drive pulse after wait_in falls drives the vector that was held.
- R7: While tri_n is low, vo_oe is 0 at once. If tri_n is still low at a drive pulse, that vector is used up, vo_oe stays 0 until the next drive pulse, and the next pulse drives the following vector.
- R8: Register 0 bits 1:0 pick the drive source: 0 internal divider, 1 external clock, 2 software strobe (bit 2 of register 6), 3 pod strobe. Bit 2 picks the external edge: 0 rising, 1 falling. Bits 4:3 pick the internal divide ratio (DIV0 to DIV3 system clocks).
- R9: A write of 1 to bit 1 of register 6 during a run ends the run. Running clears and complete sets, and later drive pulses leave the outputs unchanged.
- R10: A pulse on stat_rd clears the complete bit.
- R11: Writes to registers 0 to 5 and 7 to 9 while running have no effect.
- R12: Register 0 bits 6:5 give an offset K from 0 to 3. cap_pulse is high for one cycle K cycles after the cycle in which the outputs take a new vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | CH | Write data |
| stat_rd | input | 1 | Status read pulse, clears complete |
| stat | output | 3 | {complete, waiting, running} |
| ext_clk | input | 1 | External drive clock |
| pod_stb | input | 1 | Pod drive strobe |
| wait_in | input | 1 | Target handshake, high stalls the sequence |
| tri_n | input | 1 | Active-low float override for all outputs |
| vo_lvl | output | CH | Channel levels |
| vo_oe | output | CH | Channel drive enables |
| cap_pulse | output | 1 | Capture pulse for the input section |

## Verification
The bench goes after the window that is replayed exactly as often as asked. A design that decrements the count at the wrong time plays the window one time too many or one time too few, or never reaches the last address. It checks that a pulse arriving under wait leaves the vector in place, and that one arriving under the float override uses the vector up while keeping the pins floating. Merging these two cases would show up as a skipped or a repeated level word. It also checks the edge polarity of the external clock, the internal rate from the time a run takes, the capture offset measured against the cycle the outputs change, and that the run range cannot be rewritten during a run. Each of these is compared with a model in the bench fed by the same random vectors.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_SW  = 2'd2,
    SRC_POD = 2'd3
  } src_e;

  // configuration word, low bits of register 0
  typedef struct packed {
    logic [1:0] capoff;
    logic [1:0] rate;
    logic       pol;
    src_e       src;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam logic [3:0] RA_CFG        = 4'd0;
  localparam logic [3:0] RA_RUN_FIRST  = 4'd1;
  localparam logic [3:0] RA_RUN_LAST   = 4'd2;
  localparam logic [3:0] RA_LOOP_FIRST = 4'd3;
  localparam logic [3:0] RA_LOOP_LAST  = 4'd4;
  localparam logic [3:0] RA_LOOP_REP   = 4'd5;
  localparam logic [3:0] RA_CMD        = 4'd6;
  localparam logic [3:0] RA_PTR        = 4'd7;
  localparam logic [3:0] RA_PAT        = 4'd8;
  localparam logic [3:0] RA_ENA        = 4'd9;
endpackage

// File: rtl/vseq_clksel.sv
module vseq_clksel
  import vseq_pkg::*;
#(
  parameter int DIV0 = 40,
  parameter int DIV1 = 8,
  parameter int DIV2 = 4,
  parameter int DIV3 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  src_e       src,
  input  logic       pol,
  input  logic [1:0] rate,
  input  logic       ext_clk,
  input  logic       sw_stb,
  input  logic       pod_stb,
  output logic       tick
);
  // DIV0 is the slowest ratio and sets the counter width
  localparam int CW = $clog2(DIV0 + 1);

  logic [2:0]    ext_q;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          int_hit, ext_edge, tick_d;

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(DIV0 - 1);
      2'd1:    lim = CW'(DIV1 - 1);
      2'd2:    lim = CW'(DIV2 - 1);
      default: lim = CW'(DIV3 - 1);
    endcase
    int_hit  = (src == SRC_INT) && (cnt_q >= lim);
    cnt_d    = ((src != SRC_INT) || int_hit) ? '0 : cnt_q + 1'b1;
    ext_edge = pol ? (ext_q[2] & ~ext_q[1]) : (ext_q[1] & ~ext_q[2]);
    case (src)
      SRC_INT: tick_d = int_hit;
      SRC_EXT: tick_d = ext_edge;
      SRC_SW:  tick_d = sw_stb;
      default: tick_d = pod_stb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      ext_q <= {ext_q[1:0], ext_clk};
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  // R8: the internal divider never yields back-to-back pulses
  p_int_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src == SRC_INT) |=> !tick);
endmodule

// File: rtl/vseq_mem.sv
module vseq_mem #(
  parameter int AW = 9,
  parameter int W  = 40
) (
  input  logic          clk,
  input  logic          we_pat,
  input  logic          we_ena,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rpat,
  output logic [W-1:0]  rena
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] pat_mem [DEPTH];
  logic [W-1:0] ena_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_pat) pat_mem[waddr] <= wdata;
    if (we_ena) ena_mem[waddr] <= wdata;
    rpat <= pat_mem[raddr];
    rena <= ena_mem[raddr];
  end
endmodule

// File: rtl/vseq_core.sv
module vseq_core #(
  parameter int AW = 9,
  parameter int LW = 16,
  parameter int W  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          tick,
  input  logic          wait_s,
  input  logic          tri_s,
  input  logic          stat_rd,
  input  logic [AW-1:0] run_first,
  input  logic [AW-1:0] run_last,
  input  logic [AW-1:0] loop_first,
  input  logic [AW-1:0] loop_last,
  input  logic [LW-1:0] loop_rep,
  input  logic [W-1:0]  rpat,
  input  logic [W-1:0]  rena,
  output logic [AW-1:0] raddr,
  output logic [W-1:0]  lvl_q,
  output logic [W-1:0]  oe_q,
  output logic          running,
  output logic          waiting,
  output logic          complete,
  output logic          drv
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic          run_d, cmp_d;
  logic [W-1:0]  lvl_d, oe_d;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    run_d  = running;
    cmp_d  = complete;
    lvl_d  = lvl_q;
    oe_d   = oe_q;
    drv    = 1'b0;
    if (stat_rd) cmp_d = 1'b0;
    if (!running) begin
      if (cmd_start) begin
        addr_d = run_first;
        left_d = loop_rep;
        run_d  = 1'b1;
        cmp_d  = 1'b0;
      end
    end else if (cmd_stop) begin
      run_d = 1'b0;
      cmp_d = 1'b1;
    end else if (tick && !wait_s) begin
      drv   = 1'b1;
      lvl_d = rpat;
      oe_d  = tri_s ? rena : '0;
      if (addr_q == loop_last && left_q != '0) begin
        addr_d = loop_first;
        left_d = left_q - 1'b1;
      end else if (addr_q == run_last) begin
        run_d = 1'b0;
        cmp_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  // the memory is read at the next address, so rpat always holds the current vector
  assign raddr   = addr_d;
  assign waiting = running & wait_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      left_q   <= '0;
      running  <= 1'b0;
      complete <= 1'b0;
      lvl_q    <= '0;
      oe_q     <= '0;
    end else begin
      addr_q   <= addr_d;
      left_q   <= left_d;
      running  <= run_d;
      complete <= cmp_d;
      lvl_q    <= lvl_d;
      oe_q     <= oe_d;
    end
  end

  // R6: a stalled pulse changes neither the address nor the outputs
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wait_s && tick && !cmd_stop) |=> ($stable(addr_q) && $stable(lvl_q)));
  // R4: the complete flag is never set during a run
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !running);
  // R5: the repeat count only falls during a run
  p_loop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (left_q <= $past(left_q)));
  // R7: a vector driven under the override reaches no pin
  p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv && !tri_s) |=> (oe_q == '0));
endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int CH   = 40,
  parameter int AW   = 9,
  parameter int LW   = 16,
  parameter int DIV0 = 40,
  parameter int DIV1 = 8,
  parameter int DIV2 = 4,
  parameter int DIV3 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CH-1:0] wr_data,
  input  logic          stat_rd,
  output logic [2:0]    stat,
  input  logic          ext_clk,
  input  logic          pod_stb,
  input  logic          wait_in,
  input  logic          tri_n,
  output logic [CH-1:0] vo_lvl,
  output logic [CH-1:0] vo_oe,
  output logic          cap_pulse
);
  localparam int CAP_N = 4;

  cfg_t          cfg_q, cfg_d;
  logic [AW-1:0] rf_q, rf_d, rl_q, rl_d, lf_q, lf_d, ll_q, ll_d, ptr_q, ptr_d;
  logic [LW-1:0] rep_q, rep_d;
  logic [1:0]    wait_q, tri_q;
  logic [CAP_N-1:0] cap_q;
  logic          running, waiting, complete, drv, tick;
  logic          wr_ok, we_pat, we_ena, cmd_start, cmd_stop, sw_stb;
  logic [AW-1:0] raddr;
  logic [CH-1:0] rpat, rena, lvl_q, oe_q;

  assign wr_ok     = wr_en && !running;
  assign we_pat    = wr_ok && (wr_addr == RA_PAT);
  assign we_ena    = wr_ok && (wr_addr == RA_ENA);
  assign cmd_start = wr_en && (wr_addr == RA_CMD) && wr_data[0];
  assign cmd_stop  = wr_en && (wr_addr == RA_CMD) && wr_data[1];
  assign sw_stb    = wr_en && (wr_addr == RA_CMD) && wr_data[2];

  always_comb begin
    cfg_d = cfg_q;
    rf_d  = rf_q;
    rl_d  = rl_q;
    lf_d  = lf_q;
    ll_d  = ll_q;
    rep_d = rep_q;
    ptr_d = ptr_q;
    if (wr_ok) begin
      case (wr_addr)
        RA_CFG:        cfg_d = cfg_t'(wr_data[CFG_W-1:0]);
        RA_RUN_FIRST:  rf_d  = wr_data[AW-1:0];
        RA_RUN_LAST:   rl_d  = wr_data[AW-1:0];
        RA_LOOP_FIRST: lf_d  = wr_data[AW-1:0];
        RA_LOOP_LAST:  ll_d  = wr_data[AW-1:0];
        RA_LOOP_REP:   rep_d = wr_data[LW-1:0];
        RA_PTR:        ptr_d = wr_data[AW-1:0];
        RA_ENA:        ptr_d = ptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= cfg_t'('0);
      rf_q   <= '0;
      rl_q   <= '0;
      lf_q   <= '0;
      ll_q   <= '0;
      rep_q  <= '0;
      ptr_q  <= '0;
      wait_q <= '0;
      tri_q  <= '1;
      cap_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      rf_q   <= rf_d;
      rl_q   <= rl_d;
      lf_q   <= lf_d;
      ll_q   <= ll_d;
      rep_q  <= rep_d;
      ptr_q  <= ptr_d;
      wait_q <= {wait_q[0], wait_in};
      tri_q  <= {tri_q[0], tri_n};
      cap_q  <= {cap_q[CAP_N-2:0], drv};
    end
  end

  vseq_clksel #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_clksel (
    .clk(clk), .rst_n(rst_n), .src(cfg_q.src), .pol(cfg_q.pol), .rate(cfg_q.rate),
    .ext_clk(ext_clk), .sw_stb(sw_stb), .pod_stb(pod_stb), .tick(tick)
  );

  vseq_mem #(.AW(AW), .W(CH)) u_mem (
    .clk(clk), .we_pat(we_pat), .we_ena(we_ena), .waddr(ptr_q), .wdata(wr_data),
    .raddr(raddr), .rpat(rpat), .rena(rena)
  );

  vseq_core #(.AW(AW), .LW(LW), .W(CH)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .tick(tick), .wait_s(wait_q[1]), .tri_s(tri_q[1]), .stat_rd(stat_rd),
    .run_first(rf_q), .run_last(rl_q), .loop_first(lf_q), .loop_last(ll_q),
    .loop_rep(rep_q), .rpat(rpat), .rena(rena), .raddr(raddr),
    .lvl_q(lvl_q), .oe_q(oe_q), .running(running), .waiting(waiting),
    .complete(complete), .drv(drv)
  );

  assign vo_lvl    = lvl_q;
  assign vo_oe     = oe_q & {CH{tri_n}};
  assign cap_pulse = cap_q[cfg_q.capoff];
  assign stat      = {complete, waiting, running};

  // R11: no setting moves while a run is in progress
  p_cfg_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |->
      ($stable(cfg_q) && $stable(rf_q) && $stable(rl_q) && $stable(lf_q)
       && $stable(ll_q) && $stable(rep_q)));
endmodule

// File: tb/vseq_top_bench.sv
module vseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 40;
  localparam int AW = 9;
  localparam int NV = 64;

  logic          clk, rst_n, wr_en, stat_rd, ext_clk, pod_stb, wait_in, tri_n;
  logic [3:0]    wr_addr;
  logic [CH-1:0] wr_data, vo_lvl, vo_oe;
  logic [2:0]    stat;
  logic          cap_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [CH-1:0] pat_m [NV];
  logic [CH-1:0] ena_m [NV];

  vseq_top #(.CH(CH), .AW(AW)) u_vseq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .stat(stat), .ext_clk(ext_clk), .pod_stb(pod_stb),
    .wait_in(wait_in), .tri_n(tri_n), .vo_lvl(vo_lvl), .vo_oe(vo_oe),
    .cap_pulse(cap_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [CH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    wr(4'd6, CH'(4));
    repeat (2) @(negedge clk);
  endtask

  task automatic setup_run(input int rf, rl, lf, ll, rep);
    wr(4'd1, CH'(rf)); wr(4'd2, CH'(rl));
    wr(4'd3, CH'(lf)); wr(4'd4, CH'(ll)); wr(4'd5, CH'(rep));
    wr(4'd6, CH'(1));
  endtask

  task automatic clear_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; repeat (5) @(negedge clk);
    ext_clk = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic drive_chk(input int a, input string tag);
    strobe();
    chk(vo_lvl == pat_m[a], {tag, " level"}, 64'(vo_lvl), 64'(pat_m[a]));
    chk(vo_oe == ena_m[a], {tag, " enable"}, 64'(vo_oe), 64'(ena_m[a]));
  endtask

  // model of one software-strobed run, loop window replayed rep extra times
  task automatic model_run(input int rf, rl, lf, ll, rep);
    int a = rf;
    int left = rep;
    bit fin = 0;
    setup_run(rf, rl, lf, ll, rep);
    while (!fin) begin
      drive_chk(a, "R2 R3 R5 sequence");
      if (a == ll && left != 0) begin a = lf; left--; end
      else if (a == rl) fin = 1;
      else a++;
    end
    chk(stat == 3'b100, "R4 end of run status", 64'(stat), 64'(4));
    clear_stat();
    chk(stat == 3'b000, "R10 status read clears complete", 64'(stat), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R4 watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] prev;
    int chg_i, cap_i, cnt;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; stat_rd = 1'b0;
    ext_clk = 1'b0; pod_stb = 1'b0; wait_in = 1'b0; tri_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(vo_oe == '0, "R1 reset enables", 64'(vo_oe), 64'(0));
    chk(stat == '0, "R1 reset status", 64'(stat), 64'(0));
    chk(cap_pulse == 1'b0, "R1 reset capture", 64'(cap_pulse), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pat_m[i] = CH'({$urandom(), $urandom()});
      ena_m[i] = CH'({$urandom(), $urandom()}) | CH'(1);
    end
    wr(4'd7, '0);
    for (int i = 0; i < NV; i++) begin
      wr(4'd8, pat_m[i]);
      wr(4'd9, ena_m[i]);
    end

    // R12: capture offset 2, software source
    wr(4'd0, CH'(2 | (2 << 5)));
    setup_run(20, 22, 20, 20, 0);
    prev = vo_lvl; chg_i = -1; cap_i = -1;
    wr(4'd6, CH'(4));
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (chg_i < 0 && vo_lvl != prev) chg_i = i;
      if (cap_i < 0 && cap_pulse) cap_i = i;
    end
    chk(chg_i > 0 && cap_i - chg_i == 2, "R12 capture offset", 64'(cap_i - chg_i), 64'(2));
    strobe(); strobe();
    clear_stat();

    // R7 and R6 on one run, software source, offset 0
    wr(4'd0, CH'(2));
    setup_run(30, 33, 30, 30, 0);
    drive_chk(30, "R3 first vector");
    tri_n = 1'b0;
    @(negedge clk);
    chk(vo_oe == '0, "R7 override floats at once", 64'(vo_oe), 64'(0));
    repeat (3) @(negedge clk);
    strobe();
    chk(vo_lvl == pat_m[31], "R7 skipped vector level", 64'(vo_lvl), 64'(pat_m[31]));
    tri_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(vo_oe == '0, "R7 skipped vector stays floating", 64'(vo_oe), 64'(0));
    drive_chk(32, "R7 vector after skip");
    wait_in = 1'b1;
    repeat (3) @(negedge clk);
    strobe();
    chk(vo_lvl == pat_m[32], "R6 stalled pulse holds", 64'(vo_lvl), 64'(pat_m[32]));
    chk(stat == 3'b011, "R6 waiting status", 64'(stat), 64'(3));
    wait_in = 1'b0;
    repeat (3) @(negedge clk);
    drive_chk(33, "R6 resume after release");
    chk(stat == 3'b100, "R4 complete after last", 64'(stat), 64'(4));
    clear_stat();

    // R11: run range rewrite during a run
    setup_run(45, 50, 45, 45, 0);
    drive_chk(45, "R11 first");
    wr(4'd2, CH'(45));
    wr(4'd0, CH'(0));
    for (int a = 46; a <= 50; a++) drive_chk(a, "R11 range kept");
    chk(stat == 3'b100, "R11 run ended at original last", 64'(stat), 64'(4));
    clear_stat();

    // directed loop corner: window equals the last address
    model_run(5, 8, 6, 8, 2);

    for (int k = 0; k < 8; k++) begin
      int rf, rl, lf, ll, rep;
      rf  = $urandom_range(0, 40);
      rl  = rf + $urandom_range(0, 20);
      lf  = rf + $urandom_range(0, rl - rf);
      ll  = lf + $urandom_range(0, rl - lf);
      rep = $urandom_range(0, 3);
      model_run(rf, rl, lf, ll, rep);
    end

    // R8: internal divider rates, 3 vectors each
    wr(4'd0, CH'(0));
    setup_run(0, 2, 0, 0, 0);
    cnt = 0;
    while (!stat[2] && cnt < 500) begin @(negedge clk); cnt++; end
    chk(cnt >= 75 && cnt <= 130, "R8 slowest internal rate", 64'(cnt), 64'(100));
    clear_stat();
    wr(4'd0, CH'(3 << 3));
    setup_run(0, 2, 0, 0, 0);
    cnt = 0;
    while (!stat[2] && cnt < 500) begin @(negedge clk); cnt++; end
    chk(cnt <= 12, "R8 fastest internal rate", 64'(cnt), 64'(8));
    clear_stat();

    // R8: external clock, rising then falling edge
    wr(4'd0, CH'(1));
    setup_run(10, 12, 10, 10, 0);
    for (int a = 10; a <= 12; a++) begin
      ext_pulse();
      chk(vo_lvl == pat_m[a], "R8 external rising edge", 64'(vo_lvl), 64'(pat_m[a]));
    end
    clear_stat();
    wr(4'd0, CH'(1 | 4));
    setup_run(40, 41, 40, 40, 0);
    ext_clk = 1'b1; repeat (5) @(negedge clk);
    chk(vo_lvl == pat_m[12], "R8 rising edge ignored when falling chosen",
        64'(vo_lvl), 64'(pat_m[12]));
    ext_clk = 1'b0; repeat (5) @(negedge clk);
    chk(vo_lvl == pat_m[40], "R8 falling edge drives", 64'(vo_lvl), 64'(pat_m[40]));

    // R9: stop mid run
    wr(4'd6, CH'(2));
    @(negedge clk);
    chk(stat == 3'b100, "R9 stop status", 64'(stat), 64'(4));
    clear_stat();

    // R8: pod strobe
    wr(4'd0, CH'(3));
    setup_run(7, 9, 7, 7, 0);
    @(negedge clk); pod_stb = 1'b1;
    @(negedge clk); pod_stb = 1'b0;
    repeat (2) @(negedge clk);
    chk(vo_lvl == pat_m[7], "R8 pod strobe drives", 64'(vo_lvl), 64'(pat_m[7]));
    wr(4'd6, CH'(2));
    clear_stat();

    // R9: pulses after stop change nothing
    wr(4'd0, CH'(2));
    setup_run(50, 60, 50, 50, 0);
    drive_chk(50, "R9 before stop");
    wr(4'd6, CH'(2));
    prev = vo_lvl;
    strobe();
    chk(vo_lvl == prev, "R9 no drive after stop", 64'(vo_lvl), 64'(prev));
    chk(stat == 3'b100, "R9 stopped status", 64'(stat), 64'(4));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule